// File: doc/BRIEF.md
# TLB Invalidate-by-Address Engine

This block keeps the valid bits and page tags of a small address-translation subsystem and removes entries when an invalidate request arrives. It holds six banks. A main 4-way set-associative bank holds fixed 4 KB pages. A main 16-entry fully associative bank holds variable-size pages. The instruction side and the data side each have a first-level copy of both kinds. Requests come from a local port and from a snoop port that carries invalidates from other bus masters. Both ports are handled the same way.

Each request carries a 64-bit effective address. Bits are named below by their LSB-0 position. The 20-bit page number sits in bits 31:12. Bit 3 selects the target group and bit 2 asks for an invalidate-all. The match ignores the process ID and the address-space bit, so one request may clear many entries at once. A load port writes single entries, and its main use is test. One cycle after a request is accepted, the block pulses `done` and reports how many entries it cleared across all banks.

Top module: `tlbinv_engine`

## Requirements
- R1: The compared page number is `ea[31:12]`. Bits 63:32, the reserved bits 11:4 and bits 1:0 have no effect on the result.
- R2: `ea[3]=0` targets the set-associative group, which is the main 4-way bank and both first-level 4 KB copies. `ea[3]=1` targets the variable-page group, which is the main 16-entry bank and both 8-entry first-level copies. Banks outside the selected group are never cleared.
- R3: When `ea[2]=1`, every valid, unprotected entry of the selected group is cleared, whatever the page number.
- R4: The match uses the page tag alone. Every matching way of the indexed set is cleared, so several ways can be cleared in one request.
- R5: A set-associative bank examines only the set whose index equals the low bits of the page number. An entry in another set is kept even when its tag is equal.
- R6: A variable-page entry with size code k ignores the low 2k bits of the page number in the compare.
- R7: A variable-page entry whose protect bit is set is never cleared, and this includes invalidate-all.
- R8: One request clears matches in the main bank and in both first-level copies of its group, all in the same operation. `clr_count` gives the total over all banks.
- R9: `done` is high in the cycle after a request is accepted, and `clr_count` then holds the count. In any other cycle `done` is 0 and `clr_count` is 0.
- R10: When local and snoop requests arrive together, the local request is served first and the snoop is served in the next cycle. A lone snoop is served immediately.
- R11: After reset every entry is invalid, and `done` and `clr_count` are 0.
- R12: The write port loads valid, tag, size and protect into the entry chosen by `wr_bank` and `wr_slot`. Bank codes are 0 main set-associative, 1 instruction 4 KB copy, 2 data 4 KB copy, 3 main variable, 4 instruction variable and 5 data variable. A set-associative slot is set*4+way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_vld | input | 1 | Local invalidate request |
| loc_ea | input | 64 | Local request effective address |
| snp_vld | input | 1 | Snooped invalidate request |
| snp_ea | input | 64 | Snooped request effective address |
| wr_en | input | 1 | Entry load strobe |
| wr_bank | input | 3 | Target bank code |
| wr_slot | input | SLOT_W (6) | Entry slot in the bank |
| wr_valid | input | 1 | Valid bit to load |
| wr_vpn | input | 20 | Page tag to load |
| wr_size | input | 3 | Size code (variable banks) |
| wr_prot | input | 1 | Protect bit (variable banks) |
| done | output | 1 | Request completed pulse |
| clr_count | output | CNT_W (8) | Number of entries cleared |

## Verification
The assertions assume three things about the inputs. No entry load happens in a cycle that accepts a request. No request arrives on either port in the cycle after a collision, while the snoop is being held. Set-associative entries are only checked where the bank has not been written that cycle. The stimulus keeps to these rules by construction. Loads and requests are issued in separate cycles. Each collision is followed by an idle cycle. Random page numbers come from a small pool, and low-bit variants of it exercise the size masks.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
    localparam int VPN_W  = 20;
    localparam int SIZE_W = 3;
    localparam int WAYS   = 4;

    typedef logic [VPN_W-1:0] vpn_t;

    typedef enum logic [2:0] {
        BK_SA_MAIN  = 3'd0,
        BK_SA_I     = 3'd1,
        BK_SA_D     = 3'd2,
        BK_VAR_MAIN = 3'd3,
        BK_VAR_I    = 3'd4,
        BK_VAR_D    = 3'd5
    } bank_e;

    typedef struct packed {
        logic all;
        logic sel;
        vpn_t vpn;
    } inv_cmd_t;

    // Big-endian bits 32..51 are LSB-0 bits 31..12; bit 60 -> 3; bit 61 -> 2.
    function automatic inv_cmd_t decode_ea(input logic [63:0] ea);
        inv_cmd_t c;
        c.vpn = ea[31:12];
        c.sel = ea[3];
        c.all = ea[2];
        return c;
    endfunction

    // Size code k drops the low 2k bits of the page number from the compare.
    function automatic vpn_t size_mask(input logic [SIZE_W-1:0] sz);
        vpn_t m;
        m = '1;
        m = m << {sz, 1'b0};
        return m;
    endfunction
endpackage

// File: rtl/tlbinv_arb.sv
module tlbinv_arb (
    input  logic        clk,
    input  logic        rst,
    input  logic        loc_vld,
    input  logic [63:0] loc_ea,
    input  logic        snp_vld,
    input  logic [63:0] snp_ea,
    output logic        go,
    output logic [63:0] ea
);
    logic        hold_vld;
    logic [63:0] hold_ea;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_ea  <= '0;
        end else begin
            hold_vld <= !hold_vld && loc_vld && snp_vld;
            if (loc_vld && snp_vld) hold_ea <= snp_ea;
        end
    end

    always_comb begin
        go = hold_vld || loc_vld || snp_vld;
        if (hold_vld)     ea = hold_ea;
        else if (loc_vld) ea = loc_ea;
        else              ea = snp_ea;
    end

    // R10: input rule - nothing new arrives while a snoop is held
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        hold_vld |-> (!loc_vld && !snp_vld));
    // R10: a collision leaves the snoop for the next cycle
    p_collide_defer_r10: assert property (@(posedge clk) disable iff (rst)
        (loc_vld && snp_vld && !hold_vld) |=> (go && ea == $past(snp_ea)));
endmodule

// File: rtl/tlbinv_sa_bank.sv
module tlbinv_sa_bank
    import tlbinv_pkg::*;
#(
    parameter int SETS    = 16,
    parameter int BANK_ID = 0,
    parameter int SLOT_W  = 6,
    parameter int OUT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  vpn_t              wr_vpn,
    input  logic              go,
    input  logic              inv_all,
    input  vpn_t              inv_vpn,
    output logic [OUT_W-1:0]  clr_cnt
);
    localparam int N  = SETS * WAYS;
    localparam int IW = $clog2(SETS);
    localparam int SW = $clog2(N);

    logic [N-1:0]  vld, vld_n, hit;
    vpn_t          tag [N];
    logic [IW-1:0] idx;
    logic          wr_hit;

    assign idx    = inv_vpn[IW-1:0];
    assign wr_hit = wr_en && (wr_bank == 3'(BANK_ID)) && (32'(wr_slot) < N);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = go && vld[i] &&
                     (inv_all || ((IW'(i / WAYS) == idx) && (tag[i] == inv_vpn)));
        end
        clr_cnt = OUT_W'($countones(hit));
        vld_n   = vld;
        if (wr_hit) vld_n[wr_slot[SW-1:0]] = wr_valid;
        vld_n = vld_n & ~hit;
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= vld_n;
    end

    always_ff @(posedge clk) begin
        if (wr_hit) tag[wr_slot[SW-1:0]] <= wr_vpn;
    end

    // R3: invalidate-all empties the bank
    p_all_empties_r3: assert property (@(posedge clk) disable iff (rst)
        (go && inv_all && !wr_en) |=> (vld == '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R4: a matching way in the indexed set is gone afterwards
        p_match_cleared_r4: assert property (@(posedge clk) disable iff (rst)
            (go && !inv_all && !wr_en && vld[i] && tag[i] == inv_vpn &&
             idx == IW'(i / WAYS)) |=> !vld[i]);
        // R5: ways of other sets are untouched by a by-address request
        p_other_set_kept_r5: assert property (@(posedge clk) disable iff (rst)
            (go && !inv_all && !wr_en && vld[i] && idx != IW'(i / WAYS)) |=> vld[i]);
    end
endmodule

// File: rtl/tlbinv_var_bank.sv
module tlbinv_var_bank
    import tlbinv_pkg::*;
#(
    parameter int N       = 16,
    parameter int BANK_ID = 3,
    parameter int SLOT_W  = 6,
    parameter int OUT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  vpn_t              wr_vpn,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_prot,
    input  logic              go,
    input  logic              inv_all,
    input  vpn_t              inv_vpn,
    output logic [OUT_W-1:0]  clr_cnt
);
    localparam int SW = $clog2(N);

    logic [N-1:0]      vld, vld_n, hit, prot;
    vpn_t              tag [N];
    logic [SIZE_W-1:0] sz  [N];
    logic              wr_hit;

    assign wr_hit = wr_en && (wr_bank == 3'(BANK_ID)) && (32'(wr_slot) < N);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = go && vld[i] && !prot[i] &&
                     (inv_all || (((tag[i] ^ inv_vpn) & size_mask(sz[i])) == '0));
        end
        clr_cnt = OUT_W'($countones(hit));
        vld_n   = vld;
        if (wr_hit) vld_n[wr_slot[SW-1:0]] = wr_valid;
        vld_n = vld_n & ~hit;
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= vld_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= '0;
        end else if (wr_hit) begin
            prot[wr_slot[SW-1:0]] <= wr_prot;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_hit) begin
            tag[wr_slot[SW-1:0]] <= wr_vpn;
            sz[wr_slot[SW-1:0]]  <= wr_size;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: protected entries survive any request
        p_prot_kept_r7: assert property (@(posedge clk) disable iff (rst)
            (go && !wr_en && vld[i] && prot[i]) |=> vld[i]);
        // R3: invalidate-all removes every unprotected entry
        p_all_unprot_r3: assert property (@(posedge clk) disable iff (rst)
            (go && inv_all && !wr_en && !prot[i]) |=> !vld[i]);
    end
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
    import tlbinv_pkg::*;
#(
    parameter int  SA_SETS    = 16,
    parameter int  L1_SETS    = 4,
    parameter int  FA_N       = 16,
    parameter int  L1_VAR_N   = 8,
    localparam int SLOT_W     = $clog2(SA_SETS * WAYS),
    localparam int TOTAL      = SA_SETS * WAYS + 2 * L1_SETS * WAYS + FA_N + 2 * L1_VAR_N,
    localparam int CNT_W      = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_vld,
    input  logic [63:0]       loc_ea,
    input  logic              snp_vld,
    input  logic [63:0]       snp_ea,
    input  logic              wr_en,
    input  logic [2:0]        wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [19:0]       wr_vpn,
    input  logic [2:0]        wr_size,
    input  logic              wr_prot,
    output logic              done,
    output logic [CNT_W-1:0]  clr_count
);
    logic        arb_go;
    logic [63:0] arb_ea;
    inv_cmd_t    cmd;
    logic        sa_go, var_go;
    logic [CNT_W-1:0] bank_cnt [6];
    logic [CNT_W-1:0] total;

    tlbinv_arb u_arb (
        .clk(clk), .rst(rst),
        .loc_vld(loc_vld), .loc_ea(loc_ea),
        .snp_vld(snp_vld), .snp_ea(snp_ea),
        .go(arb_go), .ea(arb_ea)
    );

    assign cmd    = decode_ea(arb_ea);
    assign sa_go  = arb_go && !cmd.sel;
    assign var_go = arb_go &&  cmd.sel;

    for (genvar g = 0; g < 3; g++) begin : g_sa
        tlbinv_sa_bank #(
            .SETS((g == 0) ? SA_SETS : L1_SETS), .BANK_ID(g),
            .SLOT_W(SLOT_W), .OUT_W(CNT_W)
        ) u_bank (
            .clk(clk), .rst(rst),
            .wr_en(wr_en), .wr_bank(wr_bank), .wr_slot(wr_slot),
            .wr_valid(wr_valid), .wr_vpn(wr_vpn),
            .go(sa_go), .inv_all(cmd.all), .inv_vpn(cmd.vpn),
            .clr_cnt(bank_cnt[g])
        );
    end

    for (genvar g = 0; g < 3; g++) begin : g_var
        tlbinv_var_bank #(
            .N((g == 0) ? FA_N : L1_VAR_N), .BANK_ID(3 + g),
            .SLOT_W(SLOT_W), .OUT_W(CNT_W)
        ) u_bank (
            .clk(clk), .rst(rst),
            .wr_en(wr_en), .wr_bank(wr_bank), .wr_slot(wr_slot),
            .wr_valid(wr_valid), .wr_vpn(wr_vpn),
            .wr_size(wr_size), .wr_prot(wr_prot),
            .go(var_go), .inv_all(cmd.all), .inv_vpn(cmd.vpn),
            .clr_cnt(bank_cnt[3 + g])
        );
    end

    always_comb begin
        total = '0;
        for (int b = 0; b < 6; b++) total = total + bank_cnt[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            clr_count <= '0;
        end else begin
            done      <= arb_go;
            clr_count <= arb_go ? total : '0;
        end
    end

    // R12: input rule - loads never share a cycle with a served request
    p_no_load_on_go_r12: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !arb_go);
    // R9: done follows acceptance by exactly one cycle
    p_done_timing_r9: assert property (@(posedge clk) disable iff (rst)
        arb_go |=> done);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !arb_go |=> (!done && clr_count == '0));
    // R2: only the selected group reports cleared entries
    p_group_iso_r2: assert property (@(posedge clk) disable iff (rst)
        sa_go |-> (bank_cnt[3] == '0 && bank_cnt[4] == '0 && bank_cnt[5] == '0));
endmodule

// File: tb/sim_tlbinv_engine.sv
`timescale 1ns/1ps
module sim_tlbinv_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        loc_vld = 0, snp_vld = 0;
    logic [63:0] loc_ea = '0, snp_ea = '0;
    logic        wr_en = 0, wr_valid = 0, wr_prot = 0;
    logic [2:0]  wr_bank = '0, wr_size = '0;
    logic [5:0]  wr_slot = '0;
    logic [19:0] wr_vpn = '0;
    logic        done;
    logic [7:0]  clr_count;

    always #2.5 clk = ~clk;

    tlbinv_engine u0 (
        .clk(clk), .rst(rst),
        .loc_vld(loc_vld), .loc_ea(loc_ea), .snp_vld(snp_vld), .snp_ea(snp_ea),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_slot(wr_slot), .wr_valid(wr_valid),
        .wr_vpn(wr_vpn), .wr_size(wr_size), .wr_prot(wr_prot),
        .done(done), .clr_count(clr_count)
    );

    int n_chk = 0, n_fail = 0;
    bit          m_vld [6][64];
    logic [19:0] m_vpn [6][64];
    logic [2:0]  m_sz  [6][64];
    bit          m_pr  [6][64];

    function automatic int bank_n(int b);
        case (b)
            0: return 64;
            1, 2: return 16;
            3: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic int model_inv(logic [63:0] ea);
        logic [19:0] vpn = ea[31:12];
        bit sel = ea[3];
        bit all = ea[2];
        int n = 0;
        for (int b = 0; b < 6; b++) begin
            if ((b >= 3) != sel) continue;
            for (int s = 0; s < bank_n(b); s++) begin
                bit h;
                if (!m_vld[b][s]) continue;
                if (b < 3) begin
                    int sets = bank_n(b) / 4;
                    h = all || ((s / 4 == int'(vpn) % sets) && m_vpn[b][s] == vpn);
                end else begin
                    logic [19:0] mk = 20'hFFFFF << (2 * m_sz[b][s]);
                    h = !m_pr[b][s] && (all || (((m_vpn[b][s] ^ vpn) & mk) == 0));
                end
                if (h) begin
                    m_vld[b][s] = 0;
                    n++;
                end
            end
        end
        return n;
    endfunction

    function automatic logic [63:0] mk_ea(logic [19:0] vpn, bit sel, bit all);
        return {$urandom(), vpn, 8'($urandom()), sel, all, 2'($urandom())};
    endfunction

    task automatic chk(int act, int exp, string req, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_ent(int b, int slot, logic [19:0] vpn, int sz, bit pr, bit v);
        @(negedge clk);
        wr_en = 1; wr_bank = 3'(b); wr_slot = 6'(slot); wr_vpn = vpn;
        wr_size = 3'(sz); wr_prot = pr; wr_valid = v;
        m_vld[b][slot] = v; m_vpn[b][slot] = vpn; m_sz[b][slot] = 3'(sz); m_pr[b][slot] = pr;
        @(negedge clk);
        wr_en = 0;
    endtask

    // exp < 0: use the model's value
    task automatic req(bit snoop, logic [63:0] ea, int exp, string tag);
        int m;
        @(negedge clk);
        if (snoop) begin snp_vld = 1; snp_ea = ea; end
        else       begin loc_vld = 1; loc_ea = ea; end
        m = model_inv(ea);
        @(negedge clk);
        loc_vld = 0; snp_vld = 0;
        chk(int'(done), 1, "R9", {tag, " done"});
        chk(int'(clr_count), (exp < 0) ? m : exp, tag, "count");
    endtask

    task automatic collide(logic [63:0] lea, logic [63:0] sea, int e1, int e2);
        int m1, m2;
        @(negedge clk);
        loc_vld = 1; loc_ea = lea; snp_vld = 1; snp_ea = sea;
        m1 = model_inv(lea);
        @(negedge clk);
        loc_vld = 0; snp_vld = 0;
        chk(int'(clr_count), (e1 < 0) ? m1 : e1, "R10", "local first");
        m2 = model_inv(sea);
        @(negedge clk);
        chk(int'(done), 1, "R10", "held snoop done");
        chk(int'(clr_count), (e2 < 0) ? m2 : e2, "R10", "held snoop count");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [19:0] pool [8];
        void'($urandom(32'd7731));
        for (int b = 0; b < 6; b++) for (int s = 0; s < 64; s++) m_vld[b][s] = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk(int'(done), 0, "R11", "done after reset");
        chk(int'(clr_count), 0, "R11", "count after reset");
        req(0, mk_ea(20'h0, 0, 1), 0, "R11 empty sa group");
        req(0, mk_ea(20'h0, 1, 1), 0, "R11 empty var group");
        @(negedge clk);
        chk(int'(done), 0, "R9", "done drops");
        chk(int'(clr_count), 0, "R9", "count drops");

        // R4 R8 R1: multi-way hit plus first-level copy, garbage in ignored bits
        wr_ent(0, 20, 20'hABC15, 0, 0, 1);
        wr_ent(0, 21, 20'h12345, 0, 0, 1);
        wr_ent(0, 22, 20'hABC15, 0, 0, 1);
        wr_ent(0, 23, 20'hABC15, 0, 0, 1);
        wr_ent(1, 4, 20'hABC15, 0, 0, 1);
        wr_ent(2, 5, 20'h12345, 0, 0, 1);
        wr_ent(0, 24, 20'hABC15, 0, 0, 1);
        req(0, {32'hDEADBEEF, 20'hABC15, 8'hA5, 1'b0, 1'b0, 2'b11}, 4, "R4 R1 multi-way");
        req(1, mk_ea(20'h12345, 0, 0), 2, "R8 both copies via snoop");
        req(0, mk_ea(20'h00000, 0, 1), 1, "R5 off-set entry survives");

        // R6 size mask
        wr_ent(3, 0, 20'h5A5A0, 2, 0, 1);
        req(0, mk_ea(20'h5A5AF, 1, 0), 1, "R6 masked bits");
        wr_ent(3, 0, 20'h5A5A0, 2, 0, 1);
        req(0, mk_ea(20'h5A5B0, 1, 0), 0, "R6 bit above mask");
        req(0, mk_ea(20'h0, 1, 1), 1, "R3 var invalidate-all");

        // R7 protection
        wr_ent(3, 1, 20'h77700, 0, 1, 1);
        wr_ent(4, 2, 20'h77700, 0, 0, 1);
        wr_ent(5, 3, 20'h77700, 0, 1, 1);
        req(0, mk_ea(20'h77700, 1, 0), 1, "R7 by address");
        req(0, mk_ea(20'h0, 1, 1), 0, "R7 invalidate-all");
        wr_ent(3, 1, 20'h77700, 0, 0, 1);
        req(0, mk_ea(20'h0, 1, 1), 1, "R12 R7 reload unprotected");
        wr_ent(5, 3, 20'h77700, 0, 0, 0);
        req(0, mk_ea(20'h0, 1, 1), 0, "R12 cleared by load");

        // R2 group select
        wr_ent(0, 28, 20'h00077, 0, 0, 1);
        wr_ent(3, 4, 20'h00077, 0, 0, 1);
        req(0, mk_ea(20'h00077, 1, 0), 1, "R2 var group only");
        req(0, mk_ea(20'h00077, 0, 0), 1, "R2 sa group only");

        // R10 arbitration
        wr_ent(0, 4, 20'h11111, 0, 0, 1);
        wr_ent(1, 4, 20'h11111, 0, 0, 1);
        wr_ent(0, 8, 20'h22222, 0, 0, 1);
        collide(mk_ea(20'h11111, 0, 0), mk_ea(20'h22222, 0, 0), 2, 1);
        @(negedge clk);
        chk(int'(done), 0, "R9", "idle after collision");

        // random phase
        for (int i = 0; i < 8; i++) pool[i] = 20'($urandom());
        for (int it = 0; it < 400; it++) begin
            int k = $urandom_range(0, 3);
            for (int w = 0; w < k; w++) begin
                int b = $urandom_range(0, 5);
                logic [19:0] v = pool[$urandom_range(0, 7)];
                int slot;
                if (b < 3) slot = (int'(v) % (bank_n(b) / 4)) * 4 + $urandom_range(0, 3);
                else       slot = $urandom_range(0, bank_n(b) - 1);
                wr_ent(b, slot, v, $urandom_range(0, 3), ($urandom_range(0, 5) == 0),
                       ($urandom_range(0, 7) != 0));
            end
            begin
                logic [19:0] v = pool[$urandom_range(0, 7)] ^ 20'($urandom_range(0, 15) *
                                 ($urandom_range(0, 1)));
                bit sel = 1'($urandom_range(0, 1));
                bit all = ($urandom_range(0, 9) == 0);
                if ($urandom_range(0, 7) == 0)
                    collide(mk_ea(v, sel, all),
                            mk_ea(pool[$urandom_range(0, 7)], ~sel, 0), -1, -1);
                else
                    req(1'($urandom_range(0, 1)), mk_ea(v, sel, all), -1, "R4 R6 R8 random");
            end
        end
        req(0, mk_ea(20'h0, 0, 1), -1, "R3 final sa sweep");
        req(0, mk_ea(20'h0, 1, 1), -1, "R3 final var sweep");

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule